// File: doc/BRIEF.md
# Iterative Slice-Serial Adder/Subtractor

This block adds or subtracts two `WORD_W`-bit operands with one narrow `STEP_W`-bit adder, used again on every clock cycle. The operands are captured into shift registers. The lowest slice goes through the adder first, and the carry out of each slice is held in a register and fed into the next slice. The result therefore takes several cycles. In exchange, the adder's carry chain is only `STEP_W` bits long, and there is one set of operand and result registers.

Because the latency depends on the ratio of word width to slice width, both edges of the block use a ready/valid handshake. The block takes one operation at a time. New operands are accepted only after the previous result has been handed off. With the result it returns:

- the unsigned carry out of the word;
- the carry into every bit position;
- a flag that tells whether the result overflowed as a two's-complement number.

A clock enable pauses the block, and a synchronous clear returns it to idle.

Top module: `sliced_addsub`

## Requirements
- R1: When `sub` is 0 the result is `op_a + op_b`, and when `sub` is 1 the result is `op_a - op_b`. Both are taken modulo 2^`WORD_W`, and `sub` is sampled on the accepting edge.
- R2: `out_valid` rises exactly `ceil(WORD_W/STEP_W)` enabled clock cycles after the edge that accepts the operands. A partial top slice costs one full cycle.
- R3: `in_ready` is high only while the block is idle. Operands offered while an operation is in progress or waiting for hand-off are not taken and do not change the pending result.
- R4: `carry_out` is bit `WORD_W` of the unsigned sum `op_a + B' + sub`, where `B'` is `op_b` for addition and `~op_b` for subtraction.
- R5: `overflow` is 1 exactly when the two's-complement result of the chosen operation lies outside the signed `WORD_W`-bit range.
- R6: `carries[i]` equals `op_a[i] ^ B'[i] ^ result[i]` for every bit `i`, which is the carry into bit `i`.
- R7: When `clr` is high on a clock edge, on the next cycle `in_ready` is 1 and `out_valid` is 0. This holds whatever the level of `clock_en`, and it abandons any operation in progress.
- R8: While `clock_en` is low, no state changes: the handshake outputs and the result outputs hold, and the latency is extended by the number of disabled cycles.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `result`, `carry_out`, `carries` and `overflow` stay unchanged.
- R10: An enabled edge with `out_valid` and `out_ready` both high ends the operation. On the next cycle `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| clock_en | input | 1 | When low, every register holds |
| clr | input | 1 | Synchronous return to idle |
| in_valid | input | 1 | Operands and `sub` are presented |
| in_ready | output | 1 | Block is idle and will accept operands |
| sub | input | 1 | 0 selects addition, 1 selects subtraction |
| op_a | input | WORD_W | First operand |
| op_b | input | WORD_W | Second operand |
| out_valid | output | 1 | Result is available |
| out_ready | input | 1 | Consumer takes the result |
| result | output | WORD_W | Sum or difference |
| carry_out | output | 1 | Carry out of the top bit (unsigned range) |
| carries | output | WORD_W | Carry into each bit position |
| overflow | output | 1 | Signed overflow of the result |

## Verification
The bound checker assumes that `clr` is pulsed before the first operation, so the phase register starts from idle. It also assumes that the consumer samples `result` only while `out_valid` is high. Its reference result is latched on the accepting edge, so operand values that change after that edge do not matter to it. The stimulus clears both test instances at the start and runs every operand pair for both operations. It varies back-pressure, clock-enable gaps and operands offered while the block is busy. It drops `in_valid` before each output hand-off so that each pair is accepted exactly once. Two configurations are driven: one where the word divides evenly into slices and one with a partial top slice.

// File: rtl/sliced_addsub_pkg.sv
package sliced_addsub_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_DONE = 2'd2
    } phase_t;

endpackage

// File: rtl/sliced_addsub_operand_prep.sv
// Conditions the second operand for subtraction and zero-pads both operands
// to a whole number of slices. Padding is applied after inversion, so the
// carry into bit WORD_W is the true carry out of the word.
module sliced_addsub_operand_prep #(
    parameter int WORD_W = 32,
    parameter int PAD_W  = 32
) (
    input  logic [WORD_W-1:0] a_in,
    input  logic [WORD_W-1:0] b_in,
    input  logic              sub,
    output logic [PAD_W-1:0]  a_pad,
    output logic [PAD_W-1:0]  b_pad
);

    logic [WORD_W-1:0] b_cond;

    always_comb begin
        b_cond = sub ? ~b_in : b_in;
        a_pad  = PAD_W'(a_in);
        b_pad  = PAD_W'(b_cond);
    end

endmodule

// File: rtl/sliced_addsub_slice_adder.sv
// Ripple adder over one slice. It also reports the carry into each bit.
module sliced_addsub_slice_adder #(
    parameter int STEP_W = 8
) (
    input  logic [STEP_W-1:0] x,
    input  logic [STEP_W-1:0] y,
    input  logic              cin,
    output logic [STEP_W-1:0] s,
    output logic [STEP_W-1:0] cvec,
    output logic              cout
);

    always_comb begin
        logic c;
        c = cin;
        for (int i = 0; i < STEP_W; i++) begin
            cvec[i] = c;
            s[i]    = x[i] ^ y[i] ^ c;
            c       = (x[i] & y[i]) | (c & (x[i] ^ y[i]));
        end
        cout = c;
    end

endmodule

// File: rtl/sliced_addsub.sv
module sliced_addsub
    import sliced_addsub_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int STEP_W = 8
) (
    input  logic              clk,
    input  logic              clock_en,
    input  logic              clr,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              sub,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] result,
    output logic              carry_out,
    output logic [WORD_W-1:0] carries,
    output logic              overflow
);

    localparam int NSLICE = (WORD_W + STEP_W - 1) / STEP_W;
    localparam int PAD_W  = NSLICE * STEP_W;
    localparam int IDX_W  = (NSLICE > 1) ? $clog2(NSLICE) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NSLICE - 1);

    typedef struct packed {
        phase_t            ph;
        logic [IDX_W-1:0]  idx;
        logic [PAD_W-1:0]  a;
        logic [PAD_W-1:0]  b;
        logic [PAD_W-1:0]  sum;
        logic [PAD_W-1:0]  car;
        logic              cin;
    } regs_t;

    regs_t d, q;

    logic [PAD_W-1:0]  a_pad, b_pad;
    logic [STEP_W-1:0] s_sum, s_cvec;
    logic              s_cout;

    sliced_addsub_operand_prep #(
        .WORD_W (WORD_W),
        .PAD_W  (PAD_W)
    ) u_prep (
        .a_in  (op_a),
        .b_in  (op_b),
        .sub   (sub),
        .a_pad (a_pad),
        .b_pad (b_pad)
    );

    // The lowest slice of the shifting operand registers feeds the adder.
    sliced_addsub_slice_adder #(
        .STEP_W (STEP_W)
    ) u_slice (
        .x    (q.a[STEP_W-1:0]),
        .y    (q.b[STEP_W-1:0]),
        .cin  (q.cin),
        .s    (s_sum),
        .cvec (s_cvec),
        .cout (s_cout)
    );

    always_comb begin
        d = q;
        if (clock_en) begin
            unique case (q.ph)
                PH_IDLE: begin
                    if (in_valid) begin
                        d.ph  = PH_RUN;
                        d.idx = '0;
                        d.a   = a_pad;
                        d.b   = b_pad;
                        d.cin = sub;     // +1 completes the two's complement of B
                        d.sum = '0;
                        d.car = '0;
                    end
                end
                PH_RUN: begin
                    // Operands shift down one slice; results enter from the top.
                    d.a   = q.a >> STEP_W;
                    d.b   = q.b >> STEP_W;
                    d.sum = PAD_W'({s_sum, q.sum} >> STEP_W);
                    d.car = PAD_W'({s_cvec, q.car} >> STEP_W);
                    d.cin = s_cout;
                    if (q.idx == LAST_IDX) begin
                        d.ph = PH_DONE;
                    end else begin
                        d.idx = q.idx + 1'b1;
                    end
                end
                PH_DONE: begin
                    if (out_ready) begin
                        d.ph = PH_IDLE;
                    end
                end
                default: d.ph = PH_IDLE;
            endcase
        end
        if (clr) begin
            d     = '0;
            d.ph  = PH_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        q <= d;
    end

    assign in_ready  = (q.ph == PH_IDLE);
    assign out_valid = (q.ph == PH_DONE);
    assign result    = q.sum[WORD_W-1:0];

    // The carry out of the last slice stays in q.cin after the run.
    generate
        if (PAD_W == WORD_W) begin : g_exact
            assign carry_out = q.cin;
            assign carries   = q.car;
        end else begin : g_partial
            assign carry_out = q.car[WORD_W];
            assign carries   = q.car[WORD_W-1:0];
        end
    endgenerate

    assign overflow = carry_out ^ carries[WORD_W-1];

endmodule

// File: rtl/sliced_addsub_chk.sv
module sliced_addsub_chk #(
    parameter int WORD_W = 32,
    parameter int STEP_W = 8
) (
    input logic              clk,
    input logic              clock_en,
    input logic              clr,
    input logic              in_valid,
    input logic              in_ready,
    input logic              sub,
    input logic [WORD_W-1:0] op_a,
    input logic [WORD_W-1:0] op_b,
    input logic              out_valid,
    input logic              out_ready,
    input logic [WORD_W-1:0] result,
    input logic              carry_out,
    input logic [WORD_W-1:0] carries,
    input logic              overflow
);

    localparam int NSLICE = (WORD_W + STEP_W - 1) / STEP_W;
    localparam int CNT_W  = $clog2(NSLICE + 2) + 1;

    logic [CNT_W-1:0]  lat_cnt;
    logic [WORD_W-1:0] ref_res;
    logic              accept;

    assign accept = in_valid && in_ready && clock_en;

    // Enabled cycles since the accepting edge, and the reference result
    // latched on that edge.
    always_ff @(posedge clk) begin
        if (clr) begin
            lat_cnt <= '0;
            ref_res <= '0;
        end else if (accept) begin
            lat_cnt <= '0;
            ref_res <= sub ? (op_a - op_b) : (op_a + op_b);
        end else if (clock_en && !out_valid) begin
            lat_cnt <= lat_cnt + 1'b1;
        end
    end

    a_r1_result: assert property (@(posedge clk) disable iff (clr)
        out_valid |-> result == ref_res);

    a_r2_latency: assert property (@(posedge clk) disable iff (clr)
        $rose(out_valid) |-> lat_cnt == CNT_W'(NSLICE));

    a_r3_busy_not_ready: assert property (@(posedge clk) disable iff (clr)
        !(in_ready && out_valid));

    a_r8_freeze: assert property (@(posedge clk) disable iff (clr)
        !clock_en |=> $stable(in_ready) && $stable(out_valid) && $stable(result)
                      && $stable(carry_out));

    a_r9_hold: assert property (@(posedge clk) disable iff (clr)
        (out_valid && !out_ready) |=> out_valid && $stable(result) && $stable(carries)
                                      && $stable(carry_out) && $stable(overflow));

    a_r10_release: assert property (@(posedge clk) disable iff (clr)
        (out_valid && out_ready && clock_en) |=> in_ready && !out_valid);

endmodule

bind sliced_addsub sliced_addsub_chk #(
    .WORD_W (WORD_W),
    .STEP_W (STEP_W)
) u_chk (
    .clk       (clk),
    .clock_en  (clock_en),
    .clr       (clr),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .sub       (sub),
    .op_a      (op_a),
    .op_b      (op_b),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .result    (result),
    .carry_out (carry_out),
    .carries   (carries),
    .overflow  (overflow)
);

// File: tb/sliced_addsub_bench.sv
module sliced_addsub_drv #(
    parameter int W = 5,
    parameter int S = 2
) (
    input  logic clk,
    output logic done,
    output int   nchk,
    output int   nfail
);

    localparam int NS   = (W + S - 1) / S;
    localparam int MASK = (1 << W) - 1;

    logic         clock_en, clr, in_valid, sub, out_ready;
    logic         in_ready, out_valid, carry_out, overflow;
    logic [W-1:0] op_a, op_b, result, carries;

    sliced_addsub #(.WORD_W(W), .STEP_W(S)) u_sliced_addsub (
        .clk(clk), .clock_en(clock_en), .clr(clr),
        .in_valid(in_valid), .in_ready(in_ready), .sub(sub),
        .op_a(op_a), .op_b(op_b),
        .out_valid(out_valid), .out_ready(out_ready),
        .result(result), .carry_out(carry_out),
        .carries(carries), .overflow(overflow)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s W=%0d S=%0d %s: actual %0d expected %0d",
                     req, W, S, what, act, exp);
        end
    endtask

    task automatic do_clear();
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        chk(in_ready == 1'b1, "R7", "in_ready after clear", in_ready, 1);
        chk(out_valid == 1'b0, "R7", "out_valid after clear", out_valid, 0);
    endtask

    task automatic run_op(input int a, input int b, input bit s, input int stall,
                          input bit frz, input bit intrude);
        int bp, tot, esum, eco, ecar, sa, sb, r, k;
        bit eov;
        logic [W-1:0] hold_res;
        bp   = s ? (~b & MASK) : b;
        tot  = a + bp + int'(s);
        esum = tot & MASK;
        eco  = (tot >> W) & 1;
        ecar = (a ^ bp ^ esum) & MASK;
        sa   = (a >= (1 << (W - 1))) ? a - (1 << W) : a;
        sb   = (b >= (1 << (W - 1))) ? b - (1 << W) : b;
        r    = s ? sa - sb : sa + sb;
        eov  = (r > (1 << (W - 1)) - 1) || (r < -(1 << (W - 1)));

        @(negedge clk);
        in_valid = 1'b1; op_a = W'(a); op_b = W'(b); sub = s;
        @(negedge clk);
        in_valid = 1'b0;
        op_a = W'(~a); op_b = W'(~b); sub = ~s;
        chk(in_ready == 1'b0, "R3", "in_ready while busy", in_ready, 0);
        k = 1;
        if (frz) begin
            clock_en = 1'b0;
            repeat (3) begin
                @(negedge clk);
                k++;
                chk(out_valid == 1'b0 && in_ready == 1'b0, "R8",
                    "state moved while disabled", out_valid, 0);
            end
            clock_en = 1'b1;
        end
        if (intrude) in_valid = 1'b1;   // offered while busy: must be ignored
        while (!out_valid && k < NS + 20) begin
            @(negedge clk);
            k++;
        end
        chk(k == NS + 1 + (frz ? 3 : 0), "R2", "latency (negedges)", k,
            NS + 1 + (frz ? 3 : 0));
        chk(result == W'(esum), "R1", "result", result, esum);
        chk(carry_out == eco[0], "R4", "carry_out", carry_out, eco);
        chk(overflow == eov, "R5", "overflow", overflow, eov);
        chk(carries == W'(ecar), "R6", "carries", carries, ecar);
        hold_res = result;
        repeat (stall) begin
            @(negedge clk);
            chk(out_valid == 1'b1 && result == hold_res, "R9", "hold under back-pressure",
                result, hold_res);
            chk(result == W'(esum), "R3", "result after ignored operands", result, esum);
        end
        in_valid  = 1'b0;
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        chk(out_valid == 1'b0 && in_ready == 1'b1, "R10", "idle after hand-off",
            {out_valid, in_ready}, 1);
    endtask

    initial begin
        done = 1'b0; nchk = 0; nfail = 0;
        clock_en = 1'b1; clr = 1'b0; in_valid = 1'b0; sub = 1'b0;
        out_ready = 1'b0; op_a = '0; op_b = '0;
        do_clear();

        for (int s = 0; s < 2; s++) begin
            for (int a = 0; a <= MASK; a++) begin
                for (int b = 0; b <= MASK; b++) begin
                    run_op(a, b, s[0], (a + b) % 3, ((a ^ b) % 7) == 0, (a % 4) == 1);
                end
            end
        end

        // R7: clear in mid-run, with clock_en low, abandons the operation.
        @(negedge clk);
        in_valid = 1'b1; op_a = W'(3); op_b = W'(1); sub = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        clock_en = 1'b0;
        do_clear();
        clock_en = 1'b1;
        repeat (NS + 2) begin
            @(negedge clk);
            chk(out_valid == 1'b0, "R7", "no result after clear", out_valid, 0);
        end
        run_op(MASK, 1, 1'b0, 1, 1'b0, 1'b0);
        done = 1'b1;
    end

endmodule

module sliced_addsub_bench;

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic done_p, done_e;
    int   chk_p, fail_p, chk_e, fail_e;
    int   cycles = 0;
    bit   timed_out = 1'b0;

    // Partial top slice (5 = 2+2+1) and exact division (4 = 2+2).
    sliced_addsub_drv #(.W(5), .S(2)) u_part  (.clk(clk), .done(done_p), .nchk(chk_p), .nfail(fail_p));
    sliced_addsub_drv #(.W(4), .S(2)) u_exact (.clk(clk), .done(done_e), .nchk(chk_e), .nfail(fail_e));

    always @(posedge clk) cycles <= cycles + 1;

    initial begin
        int tot_chk, tot_fail;
        #1;
        while (!(done_p && done_e) && cycles < 150000) @(negedge clk);
        if (!(done_p && done_e)) begin
            timed_out = 1'b1;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        end
        tot_chk  = chk_p + chk_e + (timed_out ? 1 : 0);
        tot_fail = fail_p + fail_e + (timed_out ? 1 : 0);
        $display("End of test - %0d assertions evaluated, %0d failures", tot_chk, tot_fail);
        $finish;
    end

endmodule